// File: doc/BRIEF.md
# Port Pin Override Resolver

This block is an eight-pin slice of a general-purpose I/O port. Each pin has two register bits: an output-latch bit and a direction bit. A single pull-up disable bit applies to the whole slice. Peripherals can take over any of four pin attributes: pull-up, direction, driven value and input-buffer enable. Each takeover uses its own enable/value pair, and each pair acts independently of the other three. An attribute whose enable is low keeps its register-driven behaviour. The block resolves the pad output enable, the pad output value and the pad pull-up for every pin. It also returns the pad level through a two-flop synchroniser, and that one value feeds both the port's readable pin register and the peripherals.

A parameter `MODE` selects where the override pairs come from:

- **MODE 0:** the pairs come straight from the generic override inputs. The dedicated peripheral inputs are not used.
- **MODE 1, 2 and 3:** fixed wiring builds the pairs from the peripheral control signals. MODE 1 is a serial-peripheral-interface port, MODE 2 is an external-memory address-high port, and MODE 3 is an asynchronous/synchronous serial, two-wire and external-interrupt port. The generic override inputs are not used.

Top module: `gpio_alt_port`

## Requirements
- R1: With no override active, the pad output enable equals the direction bit (1 = output) and the pad output value equals the output-latch bit.
- R2: With no pull-up override, the pull-up request is `latch & ~pud`, and `pad_pullup` asserts only on pins whose resolved direction is input.
- R3: When a pin's pull-up override enable is 1, the pull-up request equals the override value, regardless of the latch bit and `pud`.
- R4: When a pin's direction override enable is 1, `pad_oe` equals the direction override value, whatever the direction bit holds.
- R5: When a pin's value override enable is 1, `pad_o` equals the value override, whatever the latch bit holds.
- R6: `pad_pullup` and `pad_oe` are never both 1 on the same pin.
- R7: `pin_sync` is 0 during reset. After reset it follows `pad_i` with a latency of exactly two clock edges.
- R8: A pin whose input enable resolves to 0 reads as 0 on `pin_sync`. The input enable equals the override value when the input-enable override enable is 1. Otherwise it equals `~sleep_in_off`.
- R9: MODE 1 pin map: pin 0 is select, pin 1 is clock, pin 2 is master-out data and pin 3 is master-in data. With `spi_en` = 1 in master mode:
  - Pin 3 is forced to input, with pull-up `latch & ~pud`.
  - Pins 2 and 1 drive `spi_mo` and `spi_sck_o`.

  With `spi_en` = 1 in slave mode:
  - Pins 0 to 2 are forced to input, with pull-up `latch & ~pud`.
  - Pin 3 drives `spi_so`.
- R10: In MODE 2, pin i carries `addr_hi[i]`. Pin i is overridden when `xmem_en` = 1 and `xmem_mask` < min(8-i, 7). An overridden pin is forced to output, has its pull-up forced off and drives its address bit.
- R11: MODE 3 pin map: pin 3 is transmit and pin 2 is receive. With `tx_en` = 1, pin 3 is forced to output, drives `tx_bit` and has its pull-up forced off. With `rx_en` = 1, pin 2 is forced to input and its pull-up is `latch & ~pud`.
- R12: MODE 3 pin map: pin 0 is the two-wire clock and pin 1 is the two-wire data. With `twi_en` = 1, both pins drive 0, and their output enables equal `twi_scl_o` and `twi_sda_o` respectively, which gives open-drain behaviour.
- R13: In MODE 3, pins 0 to 3 have their input enable forced to 1 while the matching `irq_en` bit is 1, even when `sleep_in_off` = 1.
- R14: In MODE 3, pin 5 drives `usart_clk_o` while `usart_sync` = 1. Its direction still follows the direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the input synchroniser |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_latch | input | N_PINS | Output-latch bits |
| port_dir | input | N_PINS | Direction bits, 1 = output |
| pud | input | 1 | Global pull-up disable |
| sleep_in_off | input | 1 | Global input-buffer disable |
| ovr_pu_en | input | N_PINS | Pull-up override enable (MODE 0) |
| ovr_pu_val | input | N_PINS | Pull-up override value (MODE 0) |
| ovr_dd_en | input | N_PINS | Direction override enable (MODE 0) |
| ovr_dd_val | input | N_PINS | Direction override value (MODE 0) |
| ovr_pv_en | input | N_PINS | Value override enable (MODE 0) |
| ovr_pv_val | input | N_PINS | Value override value (MODE 0) |
| ovr_die_en | input | N_PINS | Input-enable override enable (MODE 0) |
| ovr_die_val | input | N_PINS | Input-enable override value (MODE 0) |
| spi_en | input | 1 | Serial peripheral enabled (MODE 1) |
| spi_master | input | 1 | 1 = master role, 0 = slave role (MODE 1) |
| spi_mo | input | 1 | Master-out data (MODE 1) |
| spi_so | input | 1 | Slave-out data (MODE 1) |
| spi_sck_o | input | 1 | Clock output in master role (MODE 1) |
| xmem_en | input | 1 | External memory enabled (MODE 2) |
| xmem_mask | input | 3 | Address mask level (MODE 2) |
| addr_hi | input | 8 | Address bits 15 to 8 (MODE 2) |
| tx_en | input | 1 | Transmitter enabled (MODE 3) |
| tx_bit | input | 1 | Transmit data (MODE 3) |
| rx_en | input | 1 | Receiver enabled (MODE 3) |
| twi_en | input | 1 | Two-wire interface enabled (MODE 3) |
| twi_sda_o | input | 1 | Two-wire data pull-low request (MODE 3) |
| twi_scl_o | input | 1 | Two-wire clock pull-low request (MODE 3) |
| irq_en | input | 4 | External interrupt enables for pins 0 to 3 (MODE 3) |
| usart_sync | input | 1 | Synchronous serial mode select (MODE 3) |
| usart_clk_o | input | 1 | Synchronous serial clock output (MODE 3) |
| pad_i | input | N_PINS | Pad input levels |
| pad_oe | output | N_PINS | Resolved pad output enable |
| pad_o | output | N_PINS | Resolved pad output value |
| pad_pullup | output | N_PINS | Resolved pad pull-up |
| pin_sync | output | N_PINS | Synchronised pin value |

## Verification
The bench builds four copies of the block, all with N_PINS = 8: the generic copy (MODE 0) and one copy for each of the three preset wirings (MODE 1, 2 and 3). With all four side by side, one set of stimulus reaches both the isolated and the combined override pairs through the generic inputs. The same stimulus also exercises every preset's role-dependent forcing of direction, value and pull-up. On the generic copy, the synchroniser latency and the input-enable masking under the global disable are checked at the exact clock edges. On the MODE 3 copy, the interrupt-forced input enable is checked while the global disable is asserted.

// File: rtl/gpio_alt_port.sv
module gpio_alt_port #(
  parameter int N_PINS = 8,
  parameter int MODE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] port_latch,
  input  logic [N_PINS-1:0] port_dir,
  input  logic              pud,
  input  logic              sleep_in_off,
  input  logic [N_PINS-1:0] ovr_pu_en,
  input  logic [N_PINS-1:0] ovr_pu_val,
  input  logic [N_PINS-1:0] ovr_dd_en,
  input  logic [N_PINS-1:0] ovr_dd_val,
  input  logic [N_PINS-1:0] ovr_pv_en,
  input  logic [N_PINS-1:0] ovr_pv_val,
  input  logic [N_PINS-1:0] ovr_die_en,
  input  logic [N_PINS-1:0] ovr_die_val,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic              spi_mo,
  input  logic              spi_so,
  input  logic              spi_sck_o,
  input  logic              xmem_en,
  input  logic [2:0]        xmem_mask,
  input  logic [7:0]        addr_hi,
  input  logic              tx_en,
  input  logic              tx_bit,
  input  logic              rx_en,
  input  logic              twi_en,
  input  logic              twi_sda_o,
  input  logic              twi_scl_o,
  input  logic [3:0]        irq_en,
  input  logic              usart_sync,
  input  logic              usart_clk_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_pullup,
  output logic [N_PINS-1:0] pin_sync
);

  logic [N_PINS-1:0] pu_nrm;
  logic [N_PINS-1:0] pue, puv, dde, ddv, pve, pvv, diee, diev;
  logic [N_PINS-1:0] in_en, pu_req, s1, s2;

  assign pu_nrm = port_latch & {N_PINS{~pud}};

  always_comb begin
    pue = '0; puv = '0; dde = '0; ddv = '0;
    pve = '0; pvv = '0; diee = '0; diev = '0;
    case (MODE)
      1: begin
        pue[3] = spi_en & spi_master;
        dde[3] = spi_en & spi_master;
        pve[3] = spi_en & ~spi_master;
        pvv[3] = spi_so;
        for (int i = 0; i < 3; i++) begin
          pue[i] = spi_en & ~spi_master;
          dde[i] = spi_en & ~spi_master;
        end
        pve[2] = spi_en & spi_master;
        pvv[2] = spi_mo;
        pve[1] = spi_en & spi_master;
        pvv[1] = spi_sck_o;
        puv[3:0] = pu_nrm[3:0];
      end
      2: begin
        for (int i = 0; i < 8; i++) begin
          pue[i] = xmem_en && ({29'd0, xmem_mask} < ((i == 0) ? 32'd7 : 32'(8 - i)));
          dde[i] = pue[i];
          pve[i] = pue[i];
          ddv[i] = 1'b1;
          pvv[i] = addr_hi[i];
        end
      end
      3: begin
        pue[0] = twi_en; dde[0] = twi_en; pve[0] = twi_en;
        puv[0] = pu_nrm[0]; ddv[0] = twi_scl_o;
        pue[1] = twi_en; dde[1] = twi_en; pve[1] = twi_en;
        puv[1] = pu_nrm[1]; ddv[1] = twi_sda_o;
        pue[2] = rx_en; dde[2] = rx_en; puv[2] = pu_nrm[2];
        pue[3] = tx_en; dde[3] = tx_en; pve[3] = tx_en;
        ddv[3] = 1'b1; pvv[3] = tx_bit;
        pve[5] = usart_sync; pvv[5] = usart_clk_o;
        diee[3:0] = irq_en;
        diev[3:0] = 4'hF;
      end
      default: begin
        pue = ovr_pu_en;  puv = ovr_pu_val;
        dde = ovr_dd_en;  ddv = ovr_dd_val;
        pve = ovr_pv_en;  pvv = ovr_pv_val;
        diee = ovr_die_en; diev = ovr_die_val;
      end
    endcase
  end

  assign pad_oe     = (dde & ddv) | (~dde & port_dir);
  assign pad_o      = (pve & pvv) | (~pve & port_latch);
  assign pu_req     = (pue & puv) | (~pue & pu_nrm);
  assign pad_pullup = pu_req & ~pad_oe;
  assign in_en      = (diee & diev) | (~diee & {N_PINS{~sleep_in_off}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pad_i & in_en;
      s2 <= s1;
    end
  end

  assign pin_sync = s2;

endmodule

// File: rtl/gpio_alt_port_chk.sv
module gpio_alt_port_chk #(
  parameter int N_PINS = 8,
  parameter int MODE   = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_in_off,
  input logic [N_PINS-1:0] ovr_dd_en,
  input logic [N_PINS-1:0] ovr_dd_val,
  input logic [N_PINS-1:0] ovr_pv_en,
  input logic [N_PINS-1:0] ovr_pv_val,
  input logic [N_PINS-1:0] ovr_die_en,
  input logic [N_PINS-1:0] ovr_die_val,
  input logic [N_PINS-1:0] pad_i,
  input logic [N_PINS-1:0] pad_oe,
  input logic [N_PINS-1:0] pad_o,
  input logic [N_PINS-1:0] pad_pullup,
  input logic [N_PINS-1:0] pin_sync
);

  logic [1:0] age;
  logic [N_PINS-1:0] allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign allow = sleep_in_off ? (ovr_die_en & ovr_die_val) : ~(ovr_die_en & ~ovr_die_val);

  // R6
  pullup_input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pullup & pad_oe) == '0);

  // R4
  dir_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 0) |-> (((pad_oe ^ ovr_dd_val) & ovr_dd_en) == '0));

  // R5
  val_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 0) |-> (((pad_o ^ ovr_pv_val) & ovr_pv_en) == '0));

  // R7
  sync_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> ((pin_sync & ~$past(pad_i, 2)) == '0));

  // R8
  input_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 0 && age >= 2'd2) |-> ((pin_sync & ~$past(allow, 2)) == '0));

endmodule

bind gpio_alt_port gpio_alt_port_chk #(.N_PINS(N_PINS), .MODE(MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_in_off(sleep_in_off),
  .ovr_dd_en(ovr_dd_en), .ovr_dd_val(ovr_dd_val),
  .ovr_pv_en(ovr_pv_en), .ovr_pv_val(ovr_pv_val),
  .ovr_die_en(ovr_die_en), .ovr_die_val(ovr_die_val),
  .pad_i(pad_i), .pad_oe(pad_oe), .pad_o(pad_o),
  .pad_pullup(pad_pullup), .pin_sync(pin_sync)
);

// File: tb/sim_gpio_alt_port.sv
module sim_gpio_alt_port;
  logic clk = 0, rst_n = 0;
  logic [7:0] latch = 0, dir = 0;
  logic pud = 0, sleep = 0;
  logic [7:0] pue = 0, puv = 0, dde = 0, ddv = 0, pve = 0, pvv = 0, diee = 0, diev = 0;
  logic spi_en = 0, spi_m = 0, spi_mo = 0, spi_so = 0, spi_sck = 0;
  logic xen = 0;
  logic [2:0] xmask = 0;
  logic [7:0] addr = 0;
  logic tx_en = 0, tx_bit = 0, rx_en = 0, twi_en = 0, sda_o = 0, scl_o = 0;
  logic [3:0] irq = 0;
  logic us_sync = 0, us_clk = 0;
  logic [7:0] pad = 0;
  logic [7:0] oe [4];
  logic [7:0] o  [4];
  logic [7:0] pu [4];
  logic [7:0] ps [4];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  gpio_alt_port #(.N_PINS(8), .MODE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .port_latch(latch), .port_dir(dir), .pud(pud),
    .sleep_in_off(sleep), .ovr_pu_en(pue), .ovr_pu_val(puv), .ovr_dd_en(dde),
    .ovr_dd_val(ddv), .ovr_pv_en(pve), .ovr_pv_val(pvv), .ovr_die_en(diee),
    .ovr_die_val(diev), .spi_en(spi_en), .spi_master(spi_m), .spi_mo(spi_mo),
    .spi_so(spi_so), .spi_sck_o(spi_sck), .xmem_en(xen), .xmem_mask(xmask),
    .addr_hi(addr), .tx_en(tx_en), .tx_bit(tx_bit), .rx_en(rx_en), .twi_en(twi_en),
    .twi_sda_o(sda_o), .twi_scl_o(scl_o), .irq_en(irq), .usart_sync(us_sync),
    .usart_clk_o(us_clk), .pad_i(pad), .pad_oe(oe[0]), .pad_o(o[0]),
    .pad_pullup(pu[0]), .pin_sync(ps[0]));

  gpio_alt_port #(.N_PINS(8), .MODE(1)) u_spi (
    .clk(clk), .rst_n(rst_n), .port_latch(latch), .port_dir(dir), .pud(pud),
    .sleep_in_off(sleep), .ovr_pu_en(pue), .ovr_pu_val(puv), .ovr_dd_en(dde),
    .ovr_dd_val(ddv), .ovr_pv_en(pve), .ovr_pv_val(pvv), .ovr_die_en(diee),
    .ovr_die_val(diev), .spi_en(spi_en), .spi_master(spi_m), .spi_mo(spi_mo),
    .spi_so(spi_so), .spi_sck_o(spi_sck), .xmem_en(xen), .xmem_mask(xmask),
    .addr_hi(addr), .tx_en(tx_en), .tx_bit(tx_bit), .rx_en(rx_en), .twi_en(twi_en),
    .twi_sda_o(sda_o), .twi_scl_o(scl_o), .irq_en(irq), .usart_sync(us_sync),
    .usart_clk_o(us_clk), .pad_i(pad), .pad_oe(oe[1]), .pad_o(o[1]),
    .pad_pullup(pu[1]), .pin_sync(ps[1]));

  gpio_alt_port #(.N_PINS(8), .MODE(2)) u_addr (
    .clk(clk), .rst_n(rst_n), .port_latch(latch), .port_dir(dir), .pud(pud),
    .sleep_in_off(sleep), .ovr_pu_en(pue), .ovr_pu_val(puv), .ovr_dd_en(dde),
    .ovr_dd_val(ddv), .ovr_pv_en(pve), .ovr_pv_val(pvv), .ovr_die_en(diee),
    .ovr_die_val(diev), .spi_en(spi_en), .spi_master(spi_m), .spi_mo(spi_mo),
    .spi_so(spi_so), .spi_sck_o(spi_sck), .xmem_en(xen), .xmem_mask(xmask),
    .addr_hi(addr), .tx_en(tx_en), .tx_bit(tx_bit), .rx_en(rx_en), .twi_en(twi_en),
    .twi_sda_o(sda_o), .twi_scl_o(scl_o), .irq_en(irq), .usart_sync(us_sync),
    .usart_clk_o(us_clk), .pad_i(pad), .pad_oe(oe[2]), .pad_o(o[2]),
    .pad_pullup(pu[2]), .pin_sync(ps[2]));

  gpio_alt_port #(.N_PINS(8), .MODE(3)) u_ser (
    .clk(clk), .rst_n(rst_n), .port_latch(latch), .port_dir(dir), .pud(pud),
    .sleep_in_off(sleep), .ovr_pu_en(pue), .ovr_pu_val(puv), .ovr_dd_en(dde),
    .ovr_dd_val(ddv), .ovr_pv_en(pve), .ovr_pv_val(pvv), .ovr_die_en(diee),
    .ovr_die_val(diev), .spi_en(spi_en), .spi_master(spi_m), .spi_mo(spi_mo),
    .spi_so(spi_so), .spi_sck_o(spi_sck), .xmem_en(xen), .xmem_mask(xmask),
    .addr_hi(addr), .tx_en(tx_en), .tx_bit(tx_bit), .rx_en(rx_en), .twi_en(twi_en),
    .twi_sda_o(sda_o), .twi_scl_o(scl_o), .irq_en(irq), .usart_sync(us_sync),
    .usart_clk_o(us_clk), .pad_i(pad), .pad_oe(oe[3]), .pad_o(o[3]),
    .pad_pullup(pu[3]), .pin_sync(ps[3]));

  // {pud, latch, dir, pue, puv, dde, ddv, pve, pvv, exp_oe, exp_o, exp_pu}
  localparam logic [88:0] VEC [8] = '{
    {1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF},
    {1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00},
    {1'b0, 8'hAA, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hAA, 8'hA0},
    {1'b0, 8'h00, 8'h00, 8'hF0, 8'h30, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h30},
    {1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h05, 8'h00, 8'h00, 8'h05, 8'hFF, 8'hFA},
    {1'b0, 8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hA0, 8'hFF, 8'hAF, 8'h00},
    {1'b1, 8'h55, 8'h33, 8'h0F, 8'h0F, 8'hF0, 8'hC0, 8'h3C, 8'h24, 8'hC3, 8'h65, 8'h0C},
    {1'b0, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    pad = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset pin_sync", ps[0], 8'h00);
    rst_n = 1;
    pad = 8'h00;
    @(posedge clk); @(posedge clk);

    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      {pud, latch, dir, pue, puv, dde, ddv, pve, pvv} = VEC[k][88:24];
      #1;
      chk($sformatf("R1/R4 oe vec%0d", k), oe[0], VEC[k][23:16]);
      chk($sformatf("R1/R5 o vec%0d", k), o[0], VEC[k][15:8]);
      chk($sformatf("R2/R3/R6 pu vec%0d", k), pu[0], VEC[k][7:0]);
    end
    {pud, latch, dir, pue, puv, dde, ddv, pve, pvv} = '0;

    @(negedge clk);
    pad = 8'hA5;
    @(posedge clk); @(negedge clk);
    chk("R7 one edge", ps[0], 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R7 two edges", ps[0], 8'hA5);

    diee = 8'h0F; diev = 8'h03; sleep = 1; pad = 8'hFF;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 sleep masks", ps[0], 8'h03);
    sleep = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 override off", ps[0], 8'hF3);
    diee = 0; diev = 0;

    latch = 8'h08; dir = 8'h06; spi_en = 1; spi_m = 1; spi_mo = 1; spi_sck = 0;
    #1;
    chk("R9 master oe", oe[1], 8'h06);
    chk("R9 master o", o[1], 8'h0C);
    chk("R9 master pu", pu[1], 8'h08);
    latch = 8'h0F; dir = 8'h08; spi_m = 0; spi_so = 1;
    #1;
    chk("R9 slave oe", oe[1], 8'h08);
    chk("R9 slave o", o[1], 8'h0F);
    chk("R9 slave pu", pu[1], 8'h07);
    spi_en = 0;

    latch = 8'hFF; dir = 8'h00; xen = 1; xmask = 3'd3; addr = 8'hA5;
    #1;
    chk("R10 mask3 oe", oe[2], 8'h1F);
    chk("R10 mask3 o", o[2], 8'hE5);
    chk("R10 mask3 pu", pu[2], 8'hE0);
    xmask = 3'd0; #1;
    chk("R10 mask0 o", o[2], 8'hA5);
    chk("R10 mask0 pu", pu[2], 8'h00);
    xmask = 3'd7; #1;
    chk("R10 mask7 oe", oe[2], 8'h00);
    xmask = 3'd0; xen = 0; #1;
    chk("R10 disabled oe", oe[2], 8'h00);

    latch = 8'hFF; dir = 8'h00; twi_en = 1; scl_o = 1; sda_o = 0;
    tx_en = 1; tx_bit = 1; rx_en = 1; us_sync = 1; us_clk = 0;
    #1;
    chk("R11/R12 oe", oe[3], 8'h09);
    chk("R11/R12/R14 o", o[3], 8'hDC);
    chk("R11/R12 pu", pu[3], 8'hF6);
    twi_en = 0; tx_en = 0; rx_en = 0; latch = 8'h00; dir = 8'h20; us_clk = 1;
    #1;
    chk("R14 clk out oe", oe[3], 8'h20);
    chk("R14 clk out o", o[3], 8'h20);

    @(negedge clk);
    irq = 4'b0001; sleep = 1; pad = 8'hFF;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R13 irq keeps input", ps[3], 8'h01);

    finish_run();
  end
endmodule